// File: doc/BRIEF.md
# Lookahead Turn-Model Route Unit

This unit sits in the route stage of a 2D mesh router. A head flit comes in already carrying the output port it will leave by at this router. The unit works out which port that flit must take at the next router. The router writes this result back into the head flit, so the next router can use it the moment the flit arrives. Meanwhile the current router arbitrates for a virtual channel in parallel.

The unit first finds the coordinates of the neighbour the flit is heading to. It takes this router's coordinates and applies the one-hop offset given by the carried port. It then compares that neighbour with the destination.

A configuration input selects between two routing policies:
- Fixed dimension-order routing, which resolves X before Y.
- West-first turn-model routing. All westward travel comes first. When the destination lies east, the unit picks the least congested of the productive directions.

Both policies return only shortest paths. The result is registered, so it is valid one clock after the request.

Top module: `la_route_unit`

## Requirements
- R1: Timing. `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `out_port` takes the new result on that same edge and holds its value while `in_valid` is low.
- R2: If `cur_port` is LOCAL, the flit ejects at this router and `out_port` is LOCAL.
- R3: Port codes are LOCAL=0, EAST=1, WEST=2, NORTH=3, SOUTH=4. The next router's coordinates are found as follows: EAST adds 1 to x, WEST subtracts 1 from x, NORTH adds 1 to y, SOUTH subtracts 1 from y.
- R4: When the next router's coordinates equal the destination, `out_port` is LOCAL.
- R5: With `wf_mode`=0 (XY), the result is EAST or WEST while the destination x differs from the next router's x. Once x matches, the result is NORTH or SOUTH toward the destination y. Congestion is ignored.
- R6: With `wf_mode`=1, a destination x smaller than the next router's x gives WEST, whatever the congestion.
- R7: With `wf_mode`=1 and a destination x equal to the next router's x, the result is NORTH or SOUTH toward the destination y. A destination east in the same row gives EAST, whatever the congestion.
- R8: With `wf_mode`=1, a destination east with a y offset selects between EAST and the single productive Y port. The one whose congestion value is strictly lower wins, and EAST wins ties.
  - `cong` holds unsigned fields: bits [CW-1:0] are EAST, [2CW-1:CW] are NORTH and [3CW-1:2CW] are SOUTH.
  - The field of a non-productive port has no effect.
- R9: After reset, `out_valid` is 0 and `out_port` is LOCAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Head flit presented this cycle |
| wf_mode | input | 1 | 0 selects XY routing, 1 selects west-first |
| cur_x | input | XW | This router's x coordinate |
| cur_y | input | YW | This router's y coordinate |
| dst_x | input | XW | Destination x coordinate |
| dst_y | input | YW | Destination y coordinate |
| cur_port | input | 3 | Port precomputed for this router |
| cong | input | 3*CW | Congestion values for EAST, NORTH and SOUTH |
| out_valid | output | 1 | Result valid |
| out_port | output | 3 | Port for the next router |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the holding of the result;
- LOCAL following a LOCAL carried port;
- LOCAL on arrival at the destination;
- west-first always heading west when the destination lies west;
- XY never leaving the X axis while an X offset remains.

Only the bench scenarios can show the congestion-driven choice, with its tie order and its disregard of non-productive fields. They also cover the exact direction chosen in each mode for particular coordinate pairs.

// File: rtl/la_route_unit.sv
module la_route_unit #(
  parameter int MESH_X = 4,
  parameter int MESH_Y = 4,
  parameter int CW     = 4,
  localparam int XW = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW = (MESH_Y > 1) ? $clog2(MESH_Y) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          wf_mode,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [2:0]    cur_port,
  input  logic [3*CW-1:0] cong,
  output logic          out_valid,
  output logic [2:0]    out_port
);
  localparam logic [2:0] P_LOC = 3'd0, P_E = 3'd1, P_W = 3'd2, P_N = 3'd3, P_S = 3'd4;

  logic [XW-1:0] nx;
  logic [YW-1:0] ny;
  logic [CW-1:0] c_e, c_n, c_s, c_y;
  logic [2:0]    y_dir, pick;
  logic          go_e, go_w;

  assign nx = (cur_port == P_E) ? cur_x + 1'b1 :
              (cur_port == P_W) ? cur_x - 1'b1 : cur_x;
  assign ny = (cur_port == P_N) ? cur_y + 1'b1 :
              (cur_port == P_S) ? cur_y - 1'b1 : cur_y;

  assign c_e = cong[CW-1:0];
  assign c_n = cong[2*CW-1:CW];
  assign c_s = cong[3*CW-1:2*CW];

  assign go_e  = dst_x > nx;
  assign go_w  = dst_x < nx;
  assign y_dir = (dst_y > ny) ? P_N : (dst_y < ny) ? P_S : P_LOC;
  assign c_y   = (y_dir == P_N) ? c_n : c_s;

  always_comb begin
    if (cur_port == P_LOC)      pick = P_LOC;
    else if (go_w)              pick = P_W;
    else if (!go_e)             pick = y_dir;
    else if (!wf_mode)          pick = P_E;
    else if (y_dir != P_LOC && c_y < c_e) pick = y_dir;
    else                        pick = P_E;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= P_LOC;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_port <= pick;
    end
  end
endmodule

// File: rtl/la_route_chk.sv
module la_route_chk #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          wf_mode,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [XW-1:0] dst_x,
  input logic [YW-1:0] dst_y,
  input logic [2:0]    cur_port,
  input logic          out_valid,
  input logic [2:0]    out_port
);
  logic [XW-1:0] hop_x;
  logic [YW-1:0] hop_y;
  always_comb begin
    hop_x = cur_x;
    hop_y = cur_y;
    case (cur_port)
      3'd1: hop_x = cur_x + 1'b1;
      3'd2: hop_x = cur_x - 1'b1;
      3'd3: hop_y = cur_y + 1'b1;
      3'd4: hop_y = cur_y - 1'b1;
      default: ;
    endcase
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));
  a_r1_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_port));
  a_r2_local_carried: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(cur_port) == 3'd0) |-> out_port == 3'd0);
  a_r4_arrival_local: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(hop_x) == $past(dst_x) && $past(hop_y) == $past(dst_y))
      |-> out_port == 3'd0);
  a_r6_west_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(wf_mode) && $past(cur_port) != 3'd0
      && $past(dst_x) < $past(hop_x)) |-> out_port == 3'd2);
  a_r5_x_before_y: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(wf_mode) && $past(cur_port) != 3'd0
      && $past(dst_x) != $past(hop_x)) |-> (out_port == 3'd1 || out_port == 3'd2));
endmodule

bind la_route_unit la_route_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wf_mode(wf_mode),
  .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
  .cur_port(cur_port), .out_valid(out_valid), .out_port(out_port));

// File: tb/la_route_unit_test.sv
module la_route_unit_test;
  localparam int CW = 4;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, wf_mode = 1'b0;
  logic [1:0] cur_x = '0, cur_y = '0, dst_x = '0, dst_y = '0;
  logic [2:0] cur_port = '0;
  logic [3*CW-1:0] cong = '0;
  logic out_valid;
  logic [2:0] out_port;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  la_route_unit #(.MESH_X(4), .MESH_Y(4), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wf_mode(wf_mode),
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(dst_x), .dst_y(dst_y),
    .cur_port(cur_port), .cong(cong), .out_valid(out_valid), .out_port(out_port));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic route(input string req, input logic m, input int cx, input int cy,
                       input int cp, input int dx, input int dy,
                       input int ce, input int cn, input int cs, input int exp);
    @(negedge clk);
    wf_mode = m; cur_x = 2'(cx); cur_y = 2'(cy); cur_port = 3'(cp);
    dst_x = 2'(dx); dst_y = 2'(dy);
    cong = {4'(cs), 4'(cn), 4'(ce)};
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, int'(out_valid), 1);
    check(req, int'(out_port), exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R9 valid", int'(out_valid), 0);
    check("R9 port", int'(out_port), 0);
  endtask

  task automatic t_hold;
    route("R1 setup", 1'b0, 0, 0, 1, 3, 2, 0, 0, 0, 1);
    cur_port = 3'd2; dst_x = 2'd0; cur_x = 2'd3;
    @(negedge clk);
    check("R1 drop", int'(out_valid), 0);
    check("R1 hold", int'(out_port), 1);
  endtask

  task automatic t_xy;
    route("R5 east", 1'b0, 0, 0, 1, 3, 2, 0, 0, 0, 1);
    route("R5 turn north", 1'b0, 1, 0, 1, 2, 3, 0, 0, 0, 3);
    route("R5 west", 1'b0, 2, 3, 2, 0, 0, 0, 0, 0, 2);
    route("R5 ignores cong", 1'b0, 0, 0, 1, 3, 3, 15, 0, 0, 1);
    route("R3 south hop", 1'b0, 1, 2, 4, 1, 0, 0, 0, 0, 4);
  endtask

  task automatic t_local;
    route("R2 carried local", 1'b1, 1, 1, 0, 3, 3, 0, 0, 0, 0);
    route("R4 arrive east", 1'b0, 1, 1, 1, 2, 1, 0, 0, 0, 0);
    route("R4 R3 arrive north", 1'b1, 2, 1, 3, 2, 2, 0, 0, 0, 0);
  endtask

  task automatic t_wf;
    route("R6 west", 1'b1, 3, 1, 2, 0, 3, 0, 15, 15, 2);
    route("R7 east row", 1'b1, 0, 1, 1, 3, 1, 15, 0, 0, 1);
    route("R7 column", 1'b1, 1, 0, 1, 2, 3, 0, 0, 0, 3);
    route("R8 north less", 1'b1, 0, 0, 1, 3, 3, 5, 2, 0, 3);
    route("R8 east less", 1'b1, 0, 0, 1, 3, 3, 2, 5, 0, 1);
    route("R8 tie east", 1'b1, 0, 0, 1, 3, 3, 4, 4, 0, 1);
    route("R8 south less", 1'b1, 0, 3, 1, 3, 0, 7, 0, 1, 4);
    route("R8 south unproductive", 1'b1, 0, 0, 1, 3, 3, 6, 9, 0, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold();
        t_xy();
        t_local();
        t_wf();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule